// File: doc/BRIEF.md
# Address Window Decoder

This block takes the address of a new bus access and decides whether it falls inside one of several programmable address windows. Each window holds a base value, a mask, a translation value, a translation-enable flag and a space flag that says whether the window answers memory or I/O accesses. Only the upper `DEC_BITS` bits of the address are compared. The bits below them never affect the decision and always pass through unchanged. With the default widths the smallest window is 256 bytes.

An access starts with a one-cycle `acc_start`. The block samples the address, the access type and the latency mode on that edge, and it uses the window registers as they stand at that edge. After one, two or three clock edges it raises `dec_valid` for exactly one cycle. In that same cycle it updates the hit flag, the winning window as a one-hot vector and as an index, and the address after translation. These results stay unchanged until the next result is published. A simple write port loads any field of any window, and after reset every field holds its default.

Top module: `addr_window_decoder`

## Requirements
- R1: During and after reset, `dec_valid`, `dec_hit`, `win_oh`, `win_idx` and `out_addr` are zero. The window defaults are as follows. Window w has base `w << (DEC_BITS-2)`. Windows 0 and 2 are memory windows whose mask is all ones except the low four bits. Window 1 is an I/O window with an all-ones mask. Every other window has mask zero. All translation values and translation enables are zero.
- R2: Only `acc_addr[ADDR_W-1:ADDR_W-DEC_BITS]` takes part in the decode. The low `ADDR_W-DEC_BITS` bits never change the hit result, and they are copied to `out_addr` unchanged.
- R3: Window w matches when its mask is nonzero and `((hi ^ base) & mask) == 0`, where `hi` is the compared upper address field.
- R4: A window whose mask is zero never hits, even when the address equals its base.
- R5: A window matches only if `acc_io` equals its space flag, where 0 means memory and 1 means I/O.
- R6: When several windows match, the lowest-numbered window wins.
- R7: On a hit to a window with translation enabled, the upper field of `out_addr` is `(hi & ~mask) | (xlat & mask)`. On a hit with translation disabled, and on a miss, `out_addr` equals the sampled address.
- R8: Let the start be sampled at edge E0. `dec_valid` is high only after edge E1 when `lat_mode` is 0, only after edge E2 when it is 1, and only after edge E3 when it is 2 or 3. It is high for one cycle per accepted access.
- R9: `dec_hit`, `win_oh`, `win_idx` and `out_addr` change only in a cycle where `dec_valid` is high.
- R10: An `acc_start` that arrives while an access is still waiting out its latency is ignored. No extra `dec_valid` follows, and the pending result is not changed.
- R11: On an edge where `cfg_we` is high, field `cfg_field` of window `cfg_win` is loaded from `cfg_wdata`. The field codes are 0 for base, 1 for mask, 2 for translation value and 3 for control. In the control field, bit 0 is the space flag and bit 1 is the translation enable. A write is used by every access whose start is sampled on a later edge.
- R12: When `dec_hit` is high, `win_oh` has exactly one bit set, and that bit is bit `win_idx`. On a miss, `win_oh` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | IDX_W | Window selected for the write |
| cfg_field | input | 2 | Field code: base, mask, translation value or control |
| cfg_wdata | input | DEC_BITS | Write data |
| acc_start | input | 1 | One-cycle start of an access |
| acc_addr | input | ADDR_W | Access address |
| acc_io | input | 1 | Access type: 0 for memory, 1 for I/O |
| lat_mode | input | 2 | Decode latency: 0 fast, 1 medium, 2 or 3 slow |
| dec_valid | output | 1 | One-cycle strobe that marks a new result |
| dec_hit | output | 1 | The last access hit a window |
| win_oh | output | NUM_WIN | One-hot vector of the winning window |
| win_idx | output | IDX_W | Index of the winning window |
| out_addr | output | ADDR_W | Address after translation |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any access. They also rely on the busy state that the bind exposes, so that they only expect a result for a start that was actually accepted. The bench changes its inputs only on falling edges. It issues one extra start on purpose, while a slow decode is still pending, to check that the block ignores it. Random addresses are drawn mostly around the window bases that the bench currently has programmed, so that hits, misses, space mismatches and overlapping windows all occur often. The random register writes change only translation values and control flags, so the windows stay well defined.

// File: rtl/awd_pkg.sv
package awd_pkg;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_XLAT = 2'd2,
        FLD_CTRL = 2'd3
    } cfg_field_e;

    localparam int unsigned CTRL_IO_BIT  = 0;
    localparam int unsigned CTRL_XEN_BIT = 1;

    // latency code -> number of clock edges until the result is published
    function automatic logic [1:0] lat_edges(input logic [1:0] mode);
        case (mode)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/awd_regs.sv
module awd_regs
    import awd_pkg::*;
#(
    parameter int NUM_WIN  = 4,
    parameter int DEC_BITS = 24,
    parameter int IDX_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [IDX_W-1:0]                   win,
    input  logic [1:0]                         field,
    input  logic [DEC_BITS-1:0]                wdata,
    output logic [NUM_WIN-1:0][DEC_BITS-1:0]   base_o,
    output logic [NUM_WIN-1:0][DEC_BITS-1:0]   mask_o,
    output logic [NUM_WIN-1:0][DEC_BITS-1:0]   xlat_o,
    output logic [NUM_WIN-1:0]                 io_o,
    output logic [NUM_WIN-1:0]                 xen_o
);

    typedef struct packed {
        logic [NUM_WIN-1:0][DEC_BITS-1:0] base;
        logic [NUM_WIN-1:0][DEC_BITS-1:0] mask;
        logic [NUM_WIN-1:0][DEC_BITS-1:0] xlat;
        logic [NUM_WIN-1:0]               io;
        logic [NUM_WIN-1:0]               xen;
    } regs_t;

    regs_t r_d, r_q;

    function automatic regs_t defaults();
        regs_t v;
        for (int i = 0; i < NUM_WIN; i++) begin
            v.base[i] = DEC_BITS'(i) << (DEC_BITS - 2);
            v.xlat[i] = '0;
            v.xen[i]  = 1'b0;
            v.io[i]   = (i == 1);
            if (i == 1)
                v.mask[i] = '1;
            else if (i == 0 || i == 2)
                v.mask[i] = {{(DEC_BITS-4){1'b1}}, 4'h0};
            else
                v.mask[i] = '0;
        end
        return v;
    endfunction

    always_comb begin
        r_d = r_q;
        if (we && (int'(win) < NUM_WIN)) begin
            case (cfg_field_e'(field))
                FLD_BASE: r_d.base[win] = wdata;
                FLD_MASK: r_d.mask[win] = wdata;
                FLD_XLAT: r_d.xlat[win] = wdata;
                FLD_CTRL: begin
                    r_d.io[win]  = wdata[CTRL_IO_BIT];
                    r_d.xen[win] = wdata[CTRL_XEN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= defaults();
        else        r_q <= r_d;
    end

    assign base_o = r_q.base;
    assign mask_o = r_q.mask;
    assign xlat_o = r_q.xlat;
    assign io_o   = r_q.io;
    assign xen_o  = r_q.xen;

endmodule

// File: rtl/awd_match.sv
module awd_match #(
    parameter int NUM_WIN   = 4,
    parameter int DEC_BITS  = 24,
    parameter int IDX_W     = 2,
    parameter bit XLAT_IMPL = 1'b1
) (
    input  logic [DEC_BITS-1:0]               addr_hi,
    input  logic                              acc_io,
    input  logic [NUM_WIN-1:0][DEC_BITS-1:0]  base,
    input  logic [NUM_WIN-1:0][DEC_BITS-1:0]  mask,
    input  logic [NUM_WIN-1:0][DEC_BITS-1:0]  xlat,
    input  logic [NUM_WIN-1:0]                io_sp,
    input  logic [NUM_WIN-1:0]                xen,
    output logic                              hit,
    output logic [NUM_WIN-1:0]                oh,
    output logic [IDX_W-1:0]                  idx,
    output logic [DEC_BITS-1:0]               out_hi
);

    logic [NUM_WIN-1:0] raw;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign raw[g] = (|mask[g])
                     && (((addr_hi ^ base[g]) & mask[g]) == '0)
                     && (acc_io == io_sp[g]);
    end

    // isolate lowest set bit: lowest-numbered window wins
    assign oh  = raw & (~raw + NUM_WIN'(1));
    assign hit = |raw;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_WIN; i++)
            if (oh[i]) idx = IDX_W'(i);
    end

    if (XLAT_IMPL) begin : g_xlat
        always_comb begin
            out_hi = addr_hi;
            for (int i = 0; i < NUM_WIN; i++)
                if (oh[i] && xen[i])
                    out_hi = (addr_hi & ~mask[i]) | (xlat[i] & mask[i]);
        end
    end else begin : g_pass
        assign out_hi = addr_hi;
    end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DEC_BITS  = 24,
    parameter int NUM_WIN   = 4,
    parameter bit XLAT_IMPL = 1'b1,
    localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int LOW_W    = ADDR_W - DEC_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_win,
    input  logic [1:0]          cfg_field,
    input  logic [DEC_BITS-1:0] cfg_wdata,
    input  logic                acc_start,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_io,
    input  logic [1:0]          lat_mode,
    output logic                dec_valid,
    output logic                dec_hit,
    output logic [NUM_WIN-1:0]  win_oh,
    output logic [IDX_W-1:0]    win_idx,
    output logic [ADDR_W-1:0]   out_addr
);

    typedef struct packed {
        logic               hit;
        logic [NUM_WIN-1:0] oh;
        logic [IDX_W-1:0]   idx;
        logic [ADDR_W-1:0]  addr;
    } result_t;

    typedef struct packed {
        logic       busy;
        logic [1:0] cnt;
        result_t    pend;
        logic       valid;
        result_t    res;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_WIN-1:0][DEC_BITS-1:0] w_base, w_mask, w_xlat;
    logic [NUM_WIN-1:0]               w_io, w_xen;
    logic                             m_hit;
    logic [NUM_WIN-1:0]               m_oh;
    logic [IDX_W-1:0]                 m_idx;
    logic [DEC_BITS-1:0]              m_hi;

    awd_regs #(.NUM_WIN(NUM_WIN), .DEC_BITS(DEC_BITS), .IDX_W(IDX_W)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .win   (cfg_win),
        .field (cfg_field),
        .wdata (cfg_wdata),
        .base_o(w_base),
        .mask_o(w_mask),
        .xlat_o(w_xlat),
        .io_o  (w_io),
        .xen_o (w_xen)
    );

    awd_match #(.NUM_WIN(NUM_WIN), .DEC_BITS(DEC_BITS), .IDX_W(IDX_W),
                .XLAT_IMPL(XLAT_IMPL)) i_match (
        .addr_hi(acc_addr[ADDR_W-1 -: DEC_BITS]),
        .acc_io (acc_io),
        .base   (w_base),
        .mask   (w_mask),
        .xlat   (w_xlat),
        .io_sp  (w_io),
        .xen    (w_xen),
        .hit    (m_hit),
        .oh     (m_oh),
        .idx    (m_idx),
        .out_hi (m_hi)
    );

    always_comb begin
        result_t now;
        logic [1:0] edges;
        now.hit  = m_hit;
        now.oh   = m_oh;
        now.idx  = m_idx;
        now.addr = {m_hi, acc_addr[LOW_W-1:0]};
        edges    = lat_edges(lat_mode);

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 2'd1;
            if (st_q.cnt == 2'd1) begin
                st_d.busy  = 1'b0;
                st_d.valid = 1'b1;
                st_d.res   = st_q.pend;
            end
        end else if (acc_start) begin
            if (edges == 2'd1) begin
                st_d.valid = 1'b1;
                st_d.res   = now;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = edges - 2'd1;
                st_d.pend = now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_valid = st_q.valid;
    assign dec_hit   = st_q.res.hit;
    assign win_oh    = st_q.res.oh;
    assign win_idx   = st_q.res.idx;
    assign out_addr  = st_q.res.addr;

endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_start,
    input logic [1:0]         lat_mode,
    input logic               busy,
    input logic               dec_valid,
    input logic               dec_hit,
    input logic [NUM_WIN-1:0] win_oh,
    input logic [IDX_W-1:0]   win_idx,
    input logic [ADDR_W-1:0]  out_addr
);

    assert_lat_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !busy && lat_mode == 2'd0) |=> dec_valid);

    assert_lat_med_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !busy && lat_mode == 2'd1) |=> !dec_valid ##1 dec_valid);

    assert_lat_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !busy && lat_mode[1]) |=> !dec_valid ##1 !dec_valid ##1 dec_valid);

    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc_start) |=> (busy || dec_valid));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> ($stable(dec_hit) && $stable(win_oh)
                        && $stable(win_idx) && $stable(out_addr)));

    assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win_oh) == (dec_hit ? 1 : 0));

    assert_idx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> win_oh[win_idx]);

endmodule

bind addr_window_decoder awd_chk #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_start(acc_start),
    .lat_mode (lat_mode),
    .busy     (st_q.busy),
    .dec_valid(dec_valid),
    .dec_hit  (dec_hit),
    .win_oh   (win_oh),
    .win_idx  (win_idx),
    .out_addr (out_addr)
);

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
    localparam int AW = 32;
    localparam int DB = 24;
    localparam int NW = 4;
    localparam int IW = 2;
    localparam int LW = AW - DB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_win = '0;
    logic [1:0]    cfg_field = '0;
    logic [DB-1:0] cfg_wdata = '0;
    logic          acc_start = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_io = 1'b0;
    logic [1:0]    lat_mode = '0;
    logic          dec_valid, dec_hit;
    logic [NW-1:0] win_oh;
    logic [IW-1:0] win_idx;
    logic [AW-1:0] out_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [DB-1:0] m_base[NW];
    logic [DB-1:0] m_mask[NW];
    logic [DB-1:0] m_xlat[NW];
    logic          m_io[NW];
    logic          m_xen[NW];

    always #2 clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .acc_start(acc_start),
        .acc_addr(acc_addr), .acc_io(acc_io), .lat_mode(lat_mode),
        .dec_valid(dec_valid), .dec_hit(dec_hit), .win_oh(win_oh),
        .win_idx(win_idx), .out_addr(out_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_defaults();
        for (int i = 0; i < NW; i++) begin
            m_base[i] = DB'(i) << (DB - 2);
            m_xlat[i] = '0;
            m_xen[i]  = 1'b0;
            m_io[i]   = (i == 1);
            m_mask[i] = (i == 1) ? {DB{1'b1}} : ((i == 0 || i == 2) ? {{(DB-4){1'b1}}, 4'h0} : '0);
        end
    endtask

    function automatic void model(input logic [AW-1:0] a, input logic io,
                                  output logic h, output logic [IW-1:0] ix,
                                  output logic [NW-1:0] oh, output logic [AW-1:0] oa);
        logic [DB-1:0] hi;
        hi = a[AW-1 -: DB];
        h = 1'b0; ix = '0; oh = '0; oa = a;
        for (int i = NW - 1; i >= 0; i--) begin
            if (m_mask[i] != '0 && ((hi ^ m_base[i]) & m_mask[i]) == '0 && io == m_io[i]) begin
                h  = 1'b1;
                ix = IW'(i);
                oh = NW'(1) << i;
                oa = m_xen[i] ? {(hi & ~m_mask[i]) | (m_xlat[i] & m_mask[i]), a[LW-1:0]} : a;
            end
        end
    endfunction

    // R11: field codes 0 base, 1 mask, 2 xlat, 3 ctrl {xen, io}
    task automatic cfg_write(input int w, input logic [1:0] f, input logic [DB-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = IW'(w); cfg_field = f; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (f)
            2'd0: m_base[w] = d;
            2'd1: m_mask[w] = d;
            2'd2: m_xlat[w] = d;
            default: begin m_io[w] = d[0]; m_xen[w] = d[1]; end
        endcase
    endtask

    task automatic access(input logic [AW-1:0] a, input logic io, input logic [1:0] lm,
                          input bit poke, input string tag);
        logic          eh;
        logic [IW-1:0] ei;
        logic [NW-1:0] eo;
        logic [AW-1:0] ea;
        int            n;
        bit            lat_ok;
        model(a, io, eh, ei, eo, ea);
        n = (lm == 2'd0) ? 1 : ((lm == 2'd1) ? 2 : 3);
        @(negedge clk);
        acc_start = 1'b1; acc_addr = a; acc_io = io; lat_mode = lm;
        @(negedge clk);
        acc_start = 1'b0;
        lat_ok = 1'b1;
        for (int k = 1; k <= n; k++) begin
            if (dec_valid !== (k == n)) lat_ok = 1'b0;
            if (poke && k == 1) begin
                acc_start = 1'b1; acc_addr = ~a; acc_io = ~io; lat_mode = 2'd0;
            end else begin
                acc_start = 1'b0;
            end
            if (k < n) @(negedge clk);
        end
        acc_start = 1'b0;
        check(lat_ok, "R8 latency", 64'(lm), 64'(n));
        check(dec_hit === eh, {tag, " hit"}, 64'(dec_hit), 64'(eh));
        check(win_idx === ei && win_oh === eo, {tag, " window R12"}, {win_idx, win_oh}, {ei, eo});
        check(out_addr === ea, {tag, " address"}, 64'(out_addr), 64'(ea));
        if (poke) begin
            @(negedge clk);
            check(dec_valid === 1'b0 && out_addr === ea, "R10 start while busy ignored",
                  {dec_valid, out_addr}, {1'b0, ea});
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        set_defaults();
        repeat (3) @(negedge clk);
        check(dec_valid === 0 && dec_hit === 0 && win_oh === 0 && win_idx === 0 && out_addr === 0,
              "R1 reset outputs", {dec_valid, dec_hit, win_oh, win_idx, out_addr}, 64'd0);
        rst_n = 1'b1;

        // defaults and basic windows
        access(32'h4000_00AB, 1'b1, 2'd0, 0, "R1 R5 io window default");
        access(32'h4000_00AB, 1'b0, 2'd1, 0, "R5 space mismatch");
        access(32'hC000_0000, 1'b0, 2'd2, 0, "R4 zero mask");
        access(32'h0000_0FFF, 1'b0, 2'd3, 0, "R2 low bits ignored");
        access(32'h0000_1000, 1'b0, 2'd0, 0, "R3 outside window");
        access(32'h8000_0123, 1'b0, 2'd1, 0, "R3 window two");
        // R9 hold
        repeat (3) @(negedge clk);
        check(dec_valid === 0 && out_addr === 32'h8000_0123 && win_idx === 2'd2,
              "R9 outputs held", {dec_valid, win_idx, out_addr}, {1'b0, 2'd2, 32'h8000_0123});
        // R10 start while pending
        access(32'h0000_0055, 1'b0, 2'd2, 1, "R10 pending access");
        // R6 overlap: window 3 covers window 0
        cfg_write(3, 2'd0, '0);
        cfg_write(3, 2'd1, {{(DB-8){1'b1}}, 8'h00});
        access(32'h0000_0200, 1'b0, 2'd0, 0, "R6 lowest wins");
        // R11 + R4: disable window 0, window 3 now hits
        cfg_write(0, 2'd1, '0);
        access(32'h0000_0200, 1'b0, 2'd0, 0, "R11 R4 mask write");
        // R7 translation on window 2
        cfg_write(2, 2'd2, 24'h123456);
        cfg_write(2, 2'd3, 24'h000002);
        access(32'h8000_0ABC, 1'b0, 2'd1, 0, "R7 translation");
        cfg_write(2, 2'd3, 24'h000000);
        access(32'h8000_0ABC, 1'b0, 2'd0, 0, "R7 translation off");
        set_defaults();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int it = 0; it < 400; it++) begin
            int w;
            logic [AW-1:0] a;
            w = int'($urandom_range(0, NW - 1));
            if ($urandom_range(0, 7) == 0) begin
                if ($urandom_range(0, 1) == 0)
                    cfg_write(w, 2'd2, DB'($urandom));
                else
                    cfg_write(w, 2'd3, DB'($urandom_range(0, 3)));
            end
            a = {m_base[w] ^ (DB'($urandom) & ~m_mask[w]), LW'($urandom)};
            if ($urandom_range(0, 5) == 0) a = $urandom;
            if ($urandom_range(0, 5) == 0) a[AW - 1 - DB + 4] = ~a[AW - 1 - DB + 4];
            access(a, ($urandom_range(0, 3) == 0) ? ~m_io[w] : m_io[w],
                   2'($urandom_range(0, 3)), ($urandom_range(0, 9) == 0), "R3 R7 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule